// File: doc/BRIEF.md
# Delegated Counter Indirect Access Unit

This unit sits on the CSR side of a hart. Supervisor software uses it to read and write performance counters that machine-level software has handed down to it. Access goes through an indirect window. A select value picks a counter, and an alias slot number picks which half of which register belongs to that counter. On each access strobe the unit decides, in the same cycle, whether the access is legal. It then routes the read data from the machine-level counter and event-selector storage. Otherwise it raises either an illegal-instruction flag or a virtual-instruction flag.

An accepted write does not change storage directly. The unit merges the write data with the half of the register that is not being written. It then presents a one-hot write enable and the merged 64-bit value on a registered commit port for one cycle after the clock edge that follows the access. The external storage latches the value from that port. The machine-mode inhibit filter bit of every event selector is hidden from the alias path, both when reading and when writing.

Top module: `deleg_cnt_access`

## Requirements
- R1: Select values 0x40 through 0x5F form the window, and select 0x40+i addresses counter i. Any access with a select outside the window raises no exception, returns zero read data and produces no write enable.
- R2: The slot numbers map as follows:
  - Slot 1 is the counter low half. With XLEN 64 it is the whole counter.
  - Slot 4 is the counter high half.
  - Slot 2 is the event selector low half. With XLEN 64 it is the whole selector.
  - Slot 5 is the event selector high half.
  - Read data is zero-extended to 64 bits.
- R3: The state gates are checked first:
  - If the machine gate (gate bit 60) is closed, any window access from a mode below machine raises illegal, whatever the other inputs are.
  - If the machine gate is open but the hypervisor gate is closed, an access from a virtualized mode raises virtual.
- R4: Privilege is encoded 0 for user, 1 for supervisor and 3 for machine, and the virtualization flag marks a guest mode.
  - User mode raises illegal, and virtualized user mode raises virtual.
  - Virtualized supervisor mode raises illegal when delegation is off and virtual when it is on.
  - From machine or supervisor mode, a window access aimed at the virtualized alias set raises illegal.
  - Illegal and virtual are never raised together.
- R5: In machine or supervisor mode, any window access raises illegal while the delegation-enable bit is 0.
- R6: Slots 3 and 6, and the unused codes 0 and 7, raise illegal inside the window.
- R7: When XLEN is 64, slots 4 and 5 raise illegal. When XLEN is 32 they are accepted.
- R8: Counter index 1 (the real-time timer) always raises illegal. So does any counter whose counter-enable mask bit is 0. A committed write only ever targets a counter whose mask bit was set.
- R9: Feature checks:
  - For counters 0 and 2, slots 1 and 4 need the base-counter feature, and slots 2 and 5 need the mode-filter feature.
  - For counters 3 to 31, every slot needs the programmable-counter feature, and slot 5 also needs the overflow feature.
  - A missing feature raises illegal.
- R10: Bit 62 of an event selector reads as 0 through the alias. With XLEN 32 this is bit 30 of slot 5.
- R11: An alias write never changes bit 62 of an event selector: the committed value carries the stored bit.
- R12: An accepted write produces, one cycle later, exactly one write-enable bit for that counter's storage and the merged value. A half-width write keeps the other half. After reset no enable is set.
- R13: An access that raises an exception issues no write enable. With no strobe no exception is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| privMode | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| virtMode | input | 1 | Hart runs in a virtualized (guest) mode |
| aliasVirt | input | 1 | Access addresses the virtualized select/alias set |
| selIndex | input | SEL_W (12) | Current select register value |
| aliasSlot | input | 3 | Alias slot number 1 to 6 |
| rdStrobe | input | 1 | Alias read this cycle |
| wrStrobe | input | 1 | Alias write this cycle |
| wrData | input | DATA_W (64) | Write data |
| cntEnMask | input | 32 | Counter-enable (delegation) mask |
| delegEn | input | 1 | Delegation enable |
| machGateOpen | input | 1 | Machine state-enable bit 60 |
| hypGateOpen | input | 1 | Hypervisor state-enable bit 60 |
| xlen64 | input | 1 | XLEN is 64 (else 32) |
| featBase | input | 1 | Base counters implemented |
| featProg | input | 1 | Programmable counters implemented |
| featOvf | input | 1 | Overflow extension implemented |
| featModeFilt | input | 1 | Mode-filter extension implemented |
| ctrStore | input | 32*DATA_W | Current counter values, counter i at bits i*64 up |
| evtStore | input | 32*DATA_W | Current event selector values, same layout |
| rdData | output | DATA_W | Routed read data |
| illegalExc | output | 1 | Illegal-instruction exception |
| virtualExc | output | 1 | Virtual-instruction exception |
| ctrWrEn | output | 32 | Registered one-hot counter write enable |
| evtWrEn | output | 32 | Registered one-hot event selector write enable |
| wrValue | output | DATA_W | Registered merged value for the enabled entry |

## Verification
The bench probes the window edges at 0x3F, 0x40, 0x5F and 0x60. A design with an off-by-one window would either fault on neighbouring CSR space or let stray writes through. It walks each rule of the priority chain while another rule is also violated. This exposes a design that checks delegation before the gates, or that reports illegal where a guest should see virtual. It writes half-width values and event selectors whose stored bit 62 is set. A design that zero-fills the untouched half, leaks the filter bit on reads or lets software clear it would commit a wrong value.

// File: rtl/dcia_pkg.sv
package dcia_pkg;
  localparam int WIN_BITS  = 5;
  localparam int TIMER_IDX = 1;

  typedef enum logic [2:0] {
    SLOT_NONE   = 3'd0,
    SLOT_CTR_LO = 3'd1,
    SLOT_CFG_LO = 3'd2,
    SLOT_RSV3   = 3'd3,
    SLOT_CTR_HI = 3'd4,
    SLOT_CFG_HI = 3'd5,
    SLOT_RSV6   = 3'd6,
    SLOT_RSV7   = 3'd7
  } slot_e;

  typedef enum logic [1:0] {
    FLT_NONE,
    FLT_ILLEGAL,
    FLT_VIRTUAL
  } fault_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                rdHit;
    logic                wrHit;
    logic                pickCfg;
    logic                pickHigh;
    logic [WIN_BITS-1:0] idx;
  } dp_strobe_t;
endpackage

// File: rtl/dcia_ctrl.sv
module dcia_ctrl
  import dcia_pkg::*;
#(
  parameter int SEL_W    = 12,
  parameter int WIN_BASE = 'h40
) (
  input  logic [1:0]       privMode,
  input  logic             virtMode,
  input  logic             aliasVirt,
  input  logic [SEL_W-1:0] selIndex,
  input  logic [2:0]       aliasSlot,
  input  logic             rdStrobe,
  input  logic             wrStrobe,
  input  logic [(1<<WIN_BITS)-1:0] cntEnMask,
  input  logic             delegEn,
  input  logic             machGateOpen,
  input  logic             hypGateOpen,
  input  logic             xlen64,
  input  logic             featBase,
  input  logic             featProg,
  input  logic             featOvf,
  input  logic             featModeFilt,
  output dp_strobe_t       strobes,
  output logic             illegalExc,
  output logic             virtualExc
);
  localparam int NUM_CTR = 1 << WIN_BITS;
  localparam logic [SEL_W-1:0] WIN_LO = SEL_W'(WIN_BASE);
  localparam logic [SEL_W-1:0] WIN_HI = SEL_W'(WIN_BASE + NUM_CTR - 1);

  logic                access, inWin, isMach, isUser, guest;
  logic [WIN_BITS-1:0] idx;
  slot_e               slotK;
  logic                slotKnown, slotHigh, slotCfg, baseIdx, featOk;
  fault_e              fault;

  assign access = rdStrobe | wrStrobe;
  assign inWin  = (selIndex >= WIN_LO) && (selIndex <= WIN_HI);
  assign idx    = WIN_BITS'(selIndex - WIN_LO);
  assign isMach = (privMode == 2'b11);
  assign isUser = (privMode == 2'b00);
  assign guest  = virtMode && !isMach;
  assign slotK  = slot_e'(aliasSlot);

  always_comb begin
    slotKnown = 1'b0;
    slotHigh  = 1'b0;
    slotCfg   = 1'b0;
    unique case (slotK)
      SLOT_CTR_LO: slotKnown = 1'b1;
      SLOT_CTR_HI: begin slotKnown = 1'b1; slotHigh = 1'b1; end
      SLOT_CFG_LO: begin slotKnown = 1'b1; slotCfg = 1'b1; end
      SLOT_CFG_HI: begin slotKnown = 1'b1; slotCfg = 1'b1; slotHigh = 1'b1; end
      default:     slotKnown = 1'b0;
    endcase
  end

  // fixed counters (cycle, instret) versus programmable ones
  assign baseIdx = (idx == WIN_BITS'(0)) || (idx == WIN_BITS'(2));
  assign featOk  = baseIdx ? (slotCfg ? featModeFilt : featBase)
                           : (featProg && (!(slotCfg && slotHigh) || featOvf));

  always_comb begin
    fault = FLT_NONE;
    if (!access || !inWin)                          fault = FLT_NONE;
    else if (!isMach && !machGateOpen)              fault = FLT_ILLEGAL;
    else if (guest && !hypGateOpen)                 fault = FLT_VIRTUAL;
    else if (isUser)                                fault = guest ? FLT_VIRTUAL : FLT_ILLEGAL;
    else if (guest)                                 fault = delegEn ? FLT_VIRTUAL : FLT_ILLEGAL;
    else if (aliasVirt)                             fault = FLT_ILLEGAL;
    else if (!delegEn)                              fault = FLT_ILLEGAL;
    else if (!slotKnown)                            fault = FLT_ILLEGAL;
    else if (xlen64 && slotHigh)                    fault = FLT_ILLEGAL;
    else if (idx == WIN_BITS'(TIMER_IDX) || !cntEnMask[idx]) fault = FLT_ILLEGAL;
    else if (!featOk)                               fault = FLT_ILLEGAL;
  end

  assign illegalExc = (fault == FLT_ILLEGAL);
  assign virtualExc = (fault == FLT_VIRTUAL);

  always_comb begin
    strobes.rdHit    = rdStrobe && inWin && (fault == FLT_NONE);
    strobes.wrHit    = wrStrobe && inWin && (fault == FLT_NONE);
    strobes.pickCfg  = slotCfg;
    strobes.pickHigh = slotHigh;
    strobes.idx      = idx;
  end
endmodule

// File: rtl/dcia_dpath.sv
module dcia_dpath
  import dcia_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  dp_strobe_t                        strobes,
  input  logic                              xlen64,
  input  logic [DATA_W-1:0]                 wrData,
  input  logic [(1<<WIN_BITS)*DATA_W-1:0]   ctrStore,
  input  logic [(1<<WIN_BITS)*DATA_W-1:0]   evtStore,
  output logic [DATA_W-1:0]                 rdData,
  output logic [(1<<WIN_BITS)-1:0]          ctrWrEn,
  output logic [(1<<WIN_BITS)-1:0]          evtWrEn,
  output logic [DATA_W-1:0]                 wrValue
);
  localparam int NUM_CTR  = 1 << WIN_BITS;
  localparam int HALF_W   = DATA_W / 2;
  localparam int MINH_BIT = DATA_W - 2;
  localparam logic [DATA_W-1:0] MINH_MASK = DATA_W'(1) << MINH_BIT;

  logic [DATA_W-1:0]  curCtr, curEvt, srcRd, oldVal, newVal;
  logic [NUM_CTR-1:0] ctrWeNext, evtWeNext;

  assign curCtr = ctrStore[int'(strobes.idx)*DATA_W +: DATA_W];
  assign curEvt = evtStore[int'(strobes.idx)*DATA_W +: DATA_W];

  // read path: filter bit hidden from the alias view
  assign srcRd = strobes.pickCfg ? (curEvt & ~MINH_MASK) : curCtr;

  always_comb begin
    if (!strobes.rdHit)       rdData = '0;
    else if (xlen64)          rdData = srcRd;
    else if (strobes.pickHigh) rdData = {{HALF_W{1'b0}}, srcRd[DATA_W-1:HALF_W]};
    else                      rdData = {{HALF_W{1'b0}}, srcRd[HALF_W-1:0]};
  end

  // write path: merge the untouched half and keep the filter bit
  assign oldVal = strobes.pickCfg ? curEvt : curCtr;

  always_comb begin
    if (xlen64)                newVal = wrData;
    else if (strobes.pickHigh) newVal = {wrData[HALF_W-1:0], oldVal[HALF_W-1:0]};
    else                       newVal = {oldVal[DATA_W-1:HALF_W], wrData[HALF_W-1:0]};
    if (strobes.pickCfg)       newVal[MINH_BIT] = oldVal[MINH_BIT];
  end

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_we
    assign ctrWeNext[g] = strobes.wrHit && !strobes.pickCfg && (strobes.idx == WIN_BITS'(g));
    assign evtWeNext[g] = strobes.wrHit &&  strobes.pickCfg && (strobes.idx == WIN_BITS'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrWrEn <= '0;
      evtWrEn <= '0;
      wrValue <= '0;
    end else begin
      ctrWrEn <= ctrWeNext;
      evtWrEn <= evtWeNext;
      if (strobes.wrHit) wrValue <= newVal;
    end
  end
endmodule

// File: rtl/deleg_cnt_access.sv
module deleg_cnt_access
  import dcia_pkg::*;
#(
  parameter int SEL_W    = 12,
  parameter int WIN_BASE = 'h40,
  parameter int DATA_W   = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [1:0]                      privMode,
  input  logic                            virtMode,
  input  logic                            aliasVirt,
  input  logic [SEL_W-1:0]                selIndex,
  input  logic [2:0]                      aliasSlot,
  input  logic                            rdStrobe,
  input  logic                            wrStrobe,
  input  logic [DATA_W-1:0]               wrData,
  input  logic [(1<<WIN_BITS)-1:0]        cntEnMask,
  input  logic                            delegEn,
  input  logic                            machGateOpen,
  input  logic                            hypGateOpen,
  input  logic                            xlen64,
  input  logic                            featBase,
  input  logic                            featProg,
  input  logic                            featOvf,
  input  logic                            featModeFilt,
  input  logic [(1<<WIN_BITS)*DATA_W-1:0] ctrStore,
  input  logic [(1<<WIN_BITS)*DATA_W-1:0] evtStore,
  output logic [DATA_W-1:0]               rdData,
  output logic                            illegalExc,
  output logic                            virtualExc,
  output logic [(1<<WIN_BITS)-1:0]        ctrWrEn,
  output logic [(1<<WIN_BITS)-1:0]        evtWrEn,
  output logic [DATA_W-1:0]               wrValue
);
  dp_strobe_t strobes;

  dcia_ctrl #(.SEL_W(SEL_W), .WIN_BASE(WIN_BASE)) u_ctrl (
    .privMode(privMode), .virtMode(virtMode), .aliasVirt(aliasVirt),
    .selIndex(selIndex), .aliasSlot(aliasSlot),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .cntEnMask(cntEnMask), .delegEn(delegEn),
    .machGateOpen(machGateOpen), .hypGateOpen(hypGateOpen),
    .xlen64(xlen64), .featBase(featBase), .featProg(featProg),
    .featOvf(featOvf), .featModeFilt(featModeFilt),
    .strobes(strobes), .illegalExc(illegalExc), .virtualExc(virtualExc)
  );

  dcia_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .xlen64(xlen64),
    .wrData(wrData), .ctrStore(ctrStore), .evtStore(evtStore),
    .rdData(rdData), .ctrWrEn(ctrWrEn), .evtWrEn(evtWrEn), .wrValue(wrValue)
  );
endmodule

// File: rtl/deleg_cnt_access_chk.sv
module deleg_cnt_access_chk
  import dcia_pkg::*;
#(
  parameter int SEL_W    = 12,
  parameter int WIN_BASE = 'h40,
  parameter int DATA_W   = 64
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [1:0]                      privMode,
  input logic                            virtMode,
  input logic                            aliasVirt,
  input logic [SEL_W-1:0]                selIndex,
  input logic [2:0]                      aliasSlot,
  input logic                            rdStrobe,
  input logic                            wrStrobe,
  input logic [DATA_W-1:0]               wrData,
  input logic [(1<<WIN_BITS)-1:0]        cntEnMask,
  input logic                            delegEn,
  input logic                            machGateOpen,
  input logic                            hypGateOpen,
  input logic                            xlen64,
  input logic                            featBase,
  input logic                            featProg,
  input logic                            featOvf,
  input logic                            featModeFilt,
  input logic [(1<<WIN_BITS)*DATA_W-1:0] ctrStore,
  input logic [(1<<WIN_BITS)*DATA_W-1:0] evtStore,
  input logic [DATA_W-1:0]               rdData,
  input logic                            illegalExc,
  input logic                            virtualExc,
  input logic [(1<<WIN_BITS)-1:0]        ctrWrEn,
  input logic [(1<<WIN_BITS)-1:0]        evtWrEn,
  input logic [DATA_W-1:0]               wrValue
);
  localparam int NUM_CTR = 1 << WIN_BITS;
  logic inWin, acc, anyExc;
  assign inWin  = (int'(selIndex) >= WIN_BASE) && (int'(selIndex) < WIN_BASE + NUM_CTR);
  assign acc    = rdStrobe | wrStrobe;
  assign anyExc = illegalExc | virtualExc;

  assert_exc_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(illegalExc && virtualExc));

  assert_outside_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !inWin |-> !anyExc && rdData == '0);

  assert_gate_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && inWin && privMode != 2'b11 && !machGateOpen) |-> illegalExc);

  assert_deleg_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && inWin && !virtMode && !delegEn &&
     (privMode == 2'b11 || (privMode == 2'b01 && machGateOpen))) |-> illegalExc);

  assert_reserved_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && inWin && (aliasSlot == 3'd3 || aliasSlot == 3'd6)) |-> anyExc);

  assert_wide_high_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && inWin && xlen64 && (aliasSlot == 3'd4 || aliasSlot == 3'd5)) |-> anyExc);

  assert_timer_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && inWin && int'(selIndex) == WIN_BASE + TIMER_IDX) |-> anyExc);

  assert_commit_delegated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrWrEn != '0) |-> (($past(cntEnMask) & ctrWrEn) == ctrWrEn));

  assert_filter_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStrobe && inWin && xlen64 && aliasSlot == 3'd2 && !anyExc) |-> !rdData[DATA_W-2]);

  assert_commit_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrWrEn, evtWrEn}));

  assert_exc_blocks_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (wrStrobe && anyExc) |=> (ctrWrEn == '0 && evtWrEn == '0));

  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |-> !anyExc);
endmodule

bind deleg_cnt_access deleg_cnt_access_chk #(
  .SEL_W(SEL_W), .WIN_BASE(WIN_BASE), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/deleg_cnt_access_test.sv
module deleg_cnt_access_test;
  localparam int PER = 10;
  localparam int N   = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(PER/2) clk = ~clk;

  logic [1:0]  privMode = 2'd3;
  logic        virtMode = 0, aliasVirt = 0;
  logic [11:0] selIndex = '0;
  logic [2:0]  aliasSlot = '0;
  logic        rdStrobe = 0, wrStrobe = 0;
  logic [63:0] wrData = '0;
  logic [31:0] cntEnMask = 32'hFFFF_FFDF;
  logic        delegEn = 1, machGateOpen = 1, hypGateOpen = 1, xlen64 = 1;
  logic        featBase = 1, featProg = 1, featOvf = 1, featModeFilt = 1;
  logic [N*64-1:0] ctrStore, evtStore;
  logic [63:0] rdData, wrValue;
  logic        illegalExc, virtualExc;
  logic [31:0] ctrWrEn, evtWrEn;

  logic [63:0] ctrM [N];
  logic [63:0] evtM [N];

  always_comb
    for (int i = 0; i < N; i++) begin
      ctrStore[i*64 +: 64] = ctrM[i];
      evtStore[i*64 +: 64] = evtM[i];
    end

  // external storage latching the commit port
  always @(posedge clk)
    for (int i = 0; i < N; i++) begin
      if (ctrWrEn[i]) ctrM[i] <= wrValue;
      if (evtWrEn[i]) evtM[i] <= wrValue;
    end

  deleg_cnt_access uut (.*);

  typedef struct packed {
    logic        isCommit;
    logic [63:0] rd;
    logic        ill;
    logic        vir;
    logic [31:0] cWe;
    logic [31:0] eWe;
    logic [63:0] val;
  } item_t;

  item_t itemQ[$];
  string tagQ[$];
  event  sampleNow;
  int    nChecks = 0, nFails = 0;
  bit    finished = 0;

  task automatic chk(string tag, bit ok, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items and compares with the outputs
  initial forever begin
    @(sampleNow);
    begin
      item_t it;
      string tg;
      it = itemQ.pop_front();
      tg = tagQ.pop_front();
      if (!it.isCommit) begin
        chk({tg, " rdData"}, rdData === it.rd, rdData, it.rd);
        chk({tg, " exc"}, {illegalExc, virtualExc} === {it.ill, it.vir},
            64'({illegalExc, virtualExc}), 64'({it.ill, it.vir}));
      end else begin
        chk({tg, " ctrWrEn"}, ctrWrEn === it.cWe, 64'(ctrWrEn), 64'(it.cWe));
        chk({tg, " evtWrEn"}, evtWrEn === it.eWe, 64'(evtWrEn), 64'(it.eWe));
        if (it.cWe != 0 || it.eWe != 0)
          chk({tg, " wrValue"}, wrValue === it.val, wrValue, it.val);
      end
    end
  end

  // reference model of the requirements
  task automatic predict(input logic [11:0] sel, input logic [2:0] slot,
                         input bit r, input bit w, input logic [63:0] wd,
                         output item_t comb, output item_t com);
    bit inWin, isM, guest, ill, vir, high, cfg, known, fOk;
    int idx;
    logic [63:0] src, old, nv;
    inWin = sel >= 12'h040 && sel <= 12'h05F;
    idx   = int'(sel) - 'h40;
    isM   = privMode == 2'd3;
    guest = virtMode && !isM;
    known = slot == 1 || slot == 2 || slot == 4 || slot == 5;
    high  = slot == 4 || slot == 5;
    cfg   = slot == 2 || slot == 5;
    ill = 0; vir = 0;
    if (!(r || w) || !inWin) begin end
    else if (!isM && !machGateOpen) ill = 1;
    else if (guest && !hypGateOpen) vir = 1;
    else if (privMode == 2'd0) begin if (guest) vir = 1; else ill = 1; end
    else if (guest) begin if (delegEn) vir = 1; else ill = 1; end
    else if (aliasVirt || !delegEn || !known) ill = 1;
    else if (xlen64 && high) ill = 1;
    else if (idx == 1 || !cntEnMask[idx]) ill = 1;
    else begin
      if (idx == 0 || idx == 2) fOk = cfg ? featModeFilt : featBase;
      else fOk = featProg && (!(cfg && high) || featOvf);
      ill = !fOk;
    end
    comb = '0; com = '0; com.isCommit = 1;
    comb.ill = ill; comb.vir = vir;
    if (inWin && !ill && !vir) begin
      src = cfg ? (evtM[idx] & ~(64'd1 << 62)) : ctrM[idx];
      old = cfg ? evtM[idx] : ctrM[idx];
      if (r) comb.rd = xlen64 ? src : (high ? {32'd0, src[63:32]} : {32'd0, src[31:0]});
      if (w) begin
        if (xlen64) nv = wd;
        else if (high) nv = {wd[31:0], old[31:0]};
        else nv = {old[63:32], wd[31:0]};
        if (cfg) nv[62] = old[62];
        if (cfg) com.eWe = 32'd1 << idx; else com.cWe = 32'd1 << idx;
        com.val = nv;
      end
    end
  endtask

  task automatic access(string tag, logic [11:0] sel, logic [2:0] slot,
                        bit r, bit w, logic [63:0] wd);
    item_t a, b;
    @(negedge clk);
    predict(sel, slot, r, w, wd, a, b);
    selIndex = sel; aliasSlot = slot; rdStrobe = r; wrStrobe = w; wrData = wd;
    #1;
    itemQ.push_back(a); tagQ.push_back(tag); ->sampleNow;
    @(posedge clk); #1;
    itemQ.push_back(b); tagQ.push_back(tag); ->sampleNow;
    rdStrobe = 0; wrStrobe = 0;
    @(posedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(PER * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      ctrM[i] = {16'hC0DE, 8'(i), 8'h5A, 16'hA5A5, 8'(i), 8'h11};
      evtM[i] = 64'h4000_0000_0000_0033 | (64'(i) << 8);
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R12 reset state
    chk("R12 reset enables", ctrWrEn == 0 && evtWrEn == 0, 64'({ctrWrEn, evtWrEn}), 64'd0);
    chk("R13 reset exc", !illegalExc && !virtualExc, 64'({illegalExc, virtualExc}), 64'd0);

    // R2 / R10 read routing
    access("R2 full ctr x64", 12'h043, 3'd1, 1, 0, 0);
    access("R10 full evt x64", 12'h043, 3'd2, 1, 0, 0);
    access("R1 window top", 12'h05F, 3'd1, 1, 0, 0);
    xlen64 = 0;
    access("R2 ctr low x32", 12'h047, 3'd1, 1, 0, 0);
    access("R2 ctr high x32", 12'h047, 3'd4, 1, 0, 0);
    access("R2 evt low x32", 12'h047, 3'd2, 1, 0, 0);
    access("R10 evt high x32", 12'h047, 3'd5, 1, 0, 0);
    access("R7 high ok x32", 12'h040, 3'd4, 1, 0, 0);

    // R12 / R11 writes
    xlen64 = 1;
    access("R12 write full", 12'h044, 3'd1, 0, 1, 64'h1234_5678_9ABC_DEF0);
    access("R12 readback", 12'h044, 3'd1, 1, 0, 0);
    access("R11 keep filter x64", 12'h043, 3'd2, 0, 1, 64'h0000_0000_0000_0777);
    access("R11 readback", 12'h043, 3'd2, 1, 0, 0);
    xlen64 = 0;
    access("R12 write high half", 12'h046, 3'd4, 0, 1, 64'hFFFF_FFFF_0BAD_F00D);
    access("R12 write low half", 12'h046, 3'd1, 0, 1, 64'h0000_0000_600D_CAFE);
    access("R11 keep filter x32", 12'h048, 3'd5, 0, 1, 64'h0000_0000_0000_0042);
    access("R12 evt low x32", 12'h048, 3'd2, 0, 1, 64'h0000_0000_5555_AAAA);
    xlen64 = 1;

    // R1 window edges
    access("R1 below window", 12'h03F, 3'd1, 1, 1, 64'hDEAD);
    access("R1 above window", 12'h060, 3'd2, 1, 1, 64'hDEAD);
    access("R1 window base", 12'h040, 3'd1, 1, 0, 0);

    // R3 gates
    privMode = 2'd1; machGateOpen = 0; delegEn = 0; virtMode = 1;
    access("R3 mach gate closed guest", 12'h043, 3'd3, 1, 0, 0);
    virtMode = 0;
    access("R3 mach gate closed S", 12'h043, 3'd1, 0, 1, 64'h1);
    privMode = 2'd3; delegEn = 1;
    access("R3 M ignores gate", 12'h043, 3'd1, 1, 0, 0);
    machGateOpen = 1; hypGateOpen = 0; privMode = 2'd1; virtMode = 1; delegEn = 0;
    access("R3 hyp gate closed", 12'h043, 3'd1, 1, 0, 0);
    hypGateOpen = 1;

    // R4 modes
    access("R4 VS deleg off", 12'h043, 3'd1, 1, 0, 0);
    delegEn = 1;
    access("R4 VS deleg on", 12'h043, 3'd1, 0, 1, 64'h9);
    privMode = 2'd0;
    access("R4 VU", 12'h043, 3'd1, 1, 0, 0);
    virtMode = 0;
    access("R4 U", 12'h043, 3'd1, 1, 0, 0);
    privMode = 2'd1; aliasVirt = 1;
    access("R4 S virtual alias", 12'h043, 3'd1, 0, 1, 64'h7);
    aliasVirt = 0;
    access("R4 S legal", 12'h043, 3'd1, 1, 0, 0);

    // R5 delegation off
    delegEn = 0;
    access("R5 S deleg off write", 12'h044, 3'd1, 0, 1, 64'h55);
    privMode = 2'd3;
    access("R5 M deleg off", 12'h044, 3'd2, 1, 0, 0);
    delegEn = 1; privMode = 2'd1;

    // R6 / R7 slots
    access("R6 slot3", 12'h043, 3'd3, 1, 0, 0);
    access("R6 slot6", 12'h043, 3'd6, 0, 1, 64'h1);
    access("R6 slot0", 12'h043, 3'd0, 1, 0, 0);
    access("R7 slot4 x64", 12'h043, 3'd4, 1, 0, 0);
    access("R7 slot5 x64", 12'h043, 3'd5, 0, 1, 64'h3);

    // R8 timer and mask
    access("R8 timer index", 12'h041, 3'd1, 0, 1, 64'h1);
    access("R8 masked counter", 12'h045, 3'd2, 0, 1, 64'h1);
    access("R8 enabled counter", 12'h046, 3'd2, 1, 0, 0);

    // R9 features
    featBase = 0;
    access("R9 base missing cycle", 12'h040, 3'd1, 1, 0, 0);
    access("R9 base missing cfg ok", 12'h040, 3'd2, 1, 0, 0);
    access("R9 base missing prog ok", 12'h043, 3'd1, 1, 0, 0);
    featBase = 1; featModeFilt = 0;
    access("R9 modefilt missing", 12'h042, 3'd2, 0, 1, 64'h1);
    access("R9 modefilt ctr ok", 12'h042, 3'd1, 1, 0, 0);
    featModeFilt = 1; featProg = 0;
    access("R9 prog missing", 12'h043, 3'd1, 1, 0, 0);
    featProg = 1; featOvf = 0; xlen64 = 0;
    access("R9 ovf missing hi", 12'h043, 3'd5, 1, 0, 0);
    access("R9 ovf missing lo ok", 12'h043, 3'd2, 1, 0, 0);
    featOvf = 1; xlen64 = 1;

    // R13 idle with bad setup
    delegEn = 0;
    access("R13 no strobe", 12'h041, 3'd3, 0, 0, 0);
    delegEn = 1;

    repeat (2) @(posedge clk);
    summary();
  end
endmodule